// File: doc/BRIEF.md
# Cross-Domain Receive Error Counter

This block counts receive symbol errors that are flagged in a receive clock domain and presents the running total as a 16-bit count in a separate, asynchronous register clock domain. Each cycle in which the receive logic raises its error strobe is one event. That holds for a strobe on the last symbol of a packet and for strobes on consecutive cycles across back-to-back packets. Each event reaches the register side on its own, without waiting for later receive activity.

The receive side keeps a small free-running event counter in Gray code. The register side passes it through a multi-flop synchronizer and takes the difference from the last value it absorbed. Several events that land inside one synchronizer latency therefore arrive as a single multi-count step, and none is merged away. The register-side total saturates at all ones. A read strobe returns the current total. With the clear mode selected, the read also zeroes the total while keeping any events absorbed in that same cycle.

Top module: `rx_err_xcnt`

## Requirements
- R1: While rst_ni is low, and after it rises with no error strobes, count_o is 0. Reset clears the receive-side event counter and the register-side synchronizer and absorbed pointer, so no phantom events appear after reset.
- R2: Every rx_clk_i rising edge at which rx_err_i is high adds exactly one to count_o. This includes strobes on consecutive cycles and isolated strobes, provided reg_clk_i samples at least once per 2^EV_W-1 events.
- R3: An event becomes visible on count_o within SYNC_STAGES+1 reg_clk_i rising edges after the first reg_clk_i edge that follows it, with no further receive activity needed.
- R4: count_o saturates at 2^CNT_W-1 (0xFFFF by default) and stays there as more events arrive; it never wraps.
- R5: A read (rd_i high for one reg_clk_i cycle) with clr_on_rd_i low leaves count_o unchanged.
- R6: A read with clr_on_rd_i high returns count_o as seen during the read cycle. On the following cycle count_o holds only the events absorbed in that read cycle, which is 0 when none arrived.
- R7: Under continuous error traffic with repeated clearing reads, the sum of all values read plus the final count equals the number of strobes driven.
- R8: Outside clearing reads and reset, count_o never decreases from one reg_clk_i cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk_i | input | 1 | Receive-domain clock |
| reg_clk_i | input | 1 | Register-domain clock, asynchronous to rx_clk_i |
| rst_ni | input | 1 | Active-low asynchronous reset, synchronized per domain on release |
| rx_err_i | input | 1 | Symbol error strobe, one event per rx_clk_i cycle high |
| rd_i | input | 1 | Register read strobe, reg_clk_i domain |
| clr_on_rd_i | input | 1 | When high, a read zeroes the count after returning it |
| count_o | output | CNT_W | Saturating error total, bits 15:0 by default |

## Verification
A corrupted Gray pointer or a stale absorbed pointer on the register side shows at count_o within about three register cycles as a jump of several counts, or as a count that drifts away from the number of strobes driven. A fault in the clear path shows as a lost or doubled event in the read-plus-residual sum after a burst of clearing reads. A wrapping adder shows as a small value after the 65,535th event where all ones is expected.

// File: rtl/rx_err_xcnt_pkg.sv
package rx_err_xcnt_pkg;
  localparam int unsigned DEF_CNT_W = 16;
  localparam int unsigned DEF_EV_W = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/rx_err_rst_sync.sv
module rx_err_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= 2'b00;
    else         pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_no = pipe_q[1];
endmodule

// File: rtl/rx_err_gray_src.sv
module rx_err_gray_src #(
  parameter int unsigned EV_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            err_i,
  output logic [EV_W-1:0] gray_o
);
  logic [EV_W-1:0] bin_q, bin_d, gray_q;

  assign bin_d = bin_q + EV_W'(err_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= bin_d ^ (bin_d >> 1);
    end
  end

  assign gray_o = gray_q;

  // R2: pointer seen by the other domain moves by at most one bit per cycle
  p_gray_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/rx_err_gray_sync.sv
module rx_err_gray_sync #(
  parameter int unsigned EV_W   = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [EV_W-1:0] d_i,
  output logic [EV_W-1:0] q_o
);
  logic [EV_W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rx_err_cnt_sink.sv
module rx_err_cnt_sink #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned EV_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EV_W-1:0]  gray_i,
  input  logic             rd_i,
  input  logic             clr_on_rd_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W:0]   SAT_MAX   = {1'b0, {CNT_W{1'b1}}};
  localparam logic [CNT_W-1:0] DELTA_MAX = CNT_W'((1 << EV_W) - 1);

  logic [EV_W-1:0]  bin, seen_q, delta;
  logic [CNT_W-1:0] cnt_q, base;
  logic [CNT_W:0]   sum;
  logic             clr_now;

  always_comb begin
    for (int i = 0; i < int'(EV_W); i++) bin[i] = ^(gray_i >> i);
  end

  assign delta   = bin - seen_q;
  assign clr_now = rd_i & clr_on_rd_i;
  // events absorbed in the clearing cycle survive the clear
  assign base    = clr_now ? '0 : cnt_q;
  assign sum     = {1'b0, base} + {{(CNT_W + 1 - EV_W){1'b0}}, delta};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      cnt_q  <= '0;
    end else begin
      seen_q <= bin;
      cnt_q  <= (sum > SAT_MAX) ? SAT_MAX[CNT_W-1:0] : sum[CNT_W-1:0];
    end
  end

  assign count_o = cnt_q;

  p_no_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == SAT_MAX[CNT_W-1:0] && !clr_now) |=> cnt_q == SAT_MAX[CNT_W-1:0]);

  p_monotonic_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_now |=> cnt_q >= $past(cnt_q));

  p_clear_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_now |=> cnt_q <= DELTA_MAX);

  p_hold_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !clr_on_rd_i && $stable(gray_i) && $past(gray_i) == gray_i && cnt_q != '0)
      |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/rx_err_xcnt.sv
module rx_err_xcnt
  import rx_err_xcnt_pkg::*;
#(
  parameter int unsigned CNT_W       = DEF_CNT_W,
  parameter int unsigned EV_W        = DEF_EV_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic             rx_clk_i,
  input  logic             reg_clk_i,
  input  logic             rst_ni,
  input  logic             rx_err_i,
  input  logic             rd_i,
  input  logic             clr_on_rd_i,
  output logic [CNT_W-1:0] count_o
);
  logic rx_rst_n, reg_rst_n;
  logic [EV_W-1:0] rx_gray, reg_gray;

  rx_err_rst_sync u_rx_rst (.clk_i(rx_clk_i), .rst_ni(rst_ni), .rst_no(rx_rst_n));
  rx_err_rst_sync u_reg_rst (.clk_i(reg_clk_i), .rst_ni(rst_ni), .rst_no(reg_rst_n));

  rx_err_gray_src #(.EV_W(EV_W)) u_src (
    .clk_i (rx_clk_i),
    .rst_ni(rx_rst_n),
    .err_i (rx_err_i),
    .gray_o(rx_gray)
  );

  rx_err_gray_sync #(.EV_W(EV_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (reg_clk_i),
    .rst_ni(reg_rst_n),
    .d_i   (rx_gray),
    .q_o   (reg_gray)
  );

  rx_err_cnt_sink #(.CNT_W(CNT_W), .EV_W(EV_W)) u_sink (
    .clk_i      (reg_clk_i),
    .rst_ni     (reg_rst_n),
    .gray_i     (reg_gray),
    .rd_i       (rd_i),
    .clr_on_rd_i(clr_on_rd_i),
    .count_o    (count_o)
  );
endmodule

// File: tb/rx_err_xcnt_test.sv
module rx_err_xcnt_test;
  localparam int CLK_PERIOD = 10;
  localparam int RX_PERIOD  = 7;
  localparam int NVEC = 6;
  // {strobes, idle rx cycles between strobes}
  localparam int VEC [NVEC][2] = '{'{1, 0}, '{1, 5}, '{2, 0}, '{5, 0}, '{3, 2}, '{8, 1}};

  logic rx_clk = 0, reg_clk = 0, rst_n = 0;
  logic rx_err = 0, rd = 0, clr = 0;
  logic [15:0] count;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(RX_PERIOD / 2.0) rx_clk = ~rx_clk;
  always #(CLK_PERIOD / 2) reg_clk = ~reg_clk;

  rx_err_xcnt uut (
    .rx_clk_i(rx_clk), .reg_clk_i(reg_clk), .rst_ni(rst_n),
    .rx_err_i(rx_err), .rd_i(rd), .clr_on_rd_i(clr), .count_o(count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_errs(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge rx_clk); rx_err = 1;
      @(negedge rx_clk); rx_err = 0;
      for (int g = 0; g < gap; g++) @(negedge rx_clk);
    end
  endtask

  task automatic burst(input int n);
    @(negedge rx_clk); rx_err = 1;
    for (int i = 0; i < n; i++) @(negedge rx_clk);
    rx_err = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge rx_clk);
    repeat (6) @(negedge reg_clk);
  endtask

  task automatic do_read(input bit c, output int val);
    @(negedge reg_clk); rd = 1; clr = c; val = count;
    @(negedge reg_clk); rd = 0; clr = 0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    int exp, v, sum;
    repeat (3) @(negedge reg_clk);
    check("R1 in reset", count, 0);
    rst_n = 1;
    repeat (10) @(negedge reg_clk);
    check("R1 after reset", count, 0);

    exp = 0;
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][1] == 0) burst(VEC[k][0]);
      else pulse_errs(VEC[k][0], VEC[k][1]);
      exp += VEC[k][0];
      settle();
      check($sformatf("R2 vector %0d", k), count, exp);
    end

    // R3: single strobe visible within sync latency
    pulse_errs(1, 0);
    @(negedge reg_clk);
    repeat (4) @(negedge reg_clk);
    check("R3 latency", count, exp + 1);
    exp++;

    do_read(0, v);
    check("R5 read value", v, exp);
    repeat (3) @(negedge reg_clk);
    check("R5 no clear", count, exp);

    do_read(1, v);
    check("R6 read value", v, exp);
    check("R6 cleared", count, 0);
    repeat (4) @(negedge reg_clk);
    check("R6 stays clear", count, 0);

    // R7: clearing reads under continuous traffic
    sum = 0;
    fork
      burst(300);
      for (int r = 0; r < 60; r++) begin
        do_read(1, v); sum += v;
        @(negedge reg_clk);
      end
    join
    settle();
    do_read(1, v); sum += v;
    check("R7 no lost events", sum, 300);

    // R4: saturation
    burst(65540);
    settle();
    check("R4 saturate", count, 65535);
    pulse_errs(3, 0);
    settle();
    check("R4 no wrap", count, 65535);
    do_read(1, v);
    check("R4 read max", v, 65535);
    check("R6 cleared after max", count, 0);

    // R1: reset mid-traffic
    fork
      burst(40);
      begin repeat (10) @(negedge reg_clk); rst_n = 0; end
    join
    repeat (3) @(negedge reg_clk);
    rst_n = 1;
    repeat (12) @(negedge reg_clk);
    check("R1 reset clears", count, 0);

    done = 1;
    summary();
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end
endmodule